// File: doc/BRIEF.md
# Bus-Master DMA Channel Controller

This block is one register-programmed DMA channel. It sits between a host register port and the byte-transfer requests of a SCSI core. Software loads a start count, a start physical address and a start descriptor-list address, then issues a command. A start command copies these start values into working copies and clears the status. While the channel runs, each transfer request from the core is granted or refused according to the programmed direction. A granted request leaves the block as a one-cycle memory request whose length is clamped to the remaining count.

The channel keeps the remaining byte count and the current address, and it reports completion and interrupt status. Status clearing works in one of two ways, chosen by an external control bit: software either writes ones to the bits it wants cleared, or a read of the status word clears the sticky bits. The memory bus protocol, descriptor-list (scatter-gather) transfers and the burst-flush operation are not part of this block. The burst-flush command is accepted and does nothing.

Top module: `bmdma_channel`

## Requirements
- R1: After reset these values read back: word 0 (command) = 0, word 3 (working count) = 0, word 4 (working address) = 0xFFFFFFFF, word 5 (status) = 0 while coreIrq is low, and word 7 (working descriptor address) = 0xFFFFFFFD. After reset, dmaEnable and abortPulse are 0.
- R2: Word 1 (start count), word 2 (start address) and word 6 (start descriptor address) take a written 32-bit value and read it back unchanged.
- R3: A write to word 3, word 4 or word 7 does not change the value read back from that word.
- R4: A write to word 0 stores the value. Its bits [1:0] select the operation. Code 3 (start) copies word 1 into word 3, word 2 into word 4 and word 6 into word 7, and sets dmaEnable in the next cycle. Code 0 (idle) clears dmaEnable. Code 1 (burst-flush) leaves dmaEnable unchanged.
- R5: A start command clears all status bits [5:0].
- R6: Code 2 (abort) raises abortPulse for exactly one cycle, in the cycle after the write.
- R7: A transfer request whose direction (1 = device to memory) equals command bit 7 is granted in the same cycle. xferGrant and memReqValid are high, memLen = min(xferLen, working count), memAddr = word 2, and memDirToMem equals the requested direction.
- R8: A granted transfer lowers word 3 by memLen and raises word 4 by memLen. Both changes are visible from the next cycle.
- R9: A transfer request whose direction differs from command bit 7 is refused. xferGrant and memReqValid stay low, and words 3 and 4 are unchanged.
- R10: A pulse on coreCmdDone forces word 3 to 0 and sets status bit 3 (done). Completion takes priority over a start or a transfer in the same cycle.
- R11: When statusClrOnRead is 0, a write to word 5 clears whichever of status bits 1 (error), 2 (abort) and 3 (done) are written as 1. Other bits are left alone.
- R12: When statusClrOnRead is 1, writes to word 5 have no effect. A read of word 5 returns the current value, and bits 1 to 3 are cleared from the next cycle.
- R13: A read of word 5 shows bit 4 (SCSI interrupt) as 1 whenever coreIrq is high, whatever the stored bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clear-on-read side effect) |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| statusClrOnRead | input | 1 | 1: status clears on read, 0: write-one-to-clear |
| coreIrq | input | 1 | Interrupt flag of the SCSI core |
| coreCmdDone | input | 1 | Command-completion pulse from the SCSI core |
| xferReq | input | 1 | Transfer request from the SCSI core |
| xferDirToMem | input | 1 | Requested direction, 1 = device to memory |
| xferLen | input | 16 | Requested length in bytes |
| xferGrant | output | 1 | Request accepted this cycle |
| memReqValid | output | 1 | Memory request strobe |
| memAddr | output | 32 | Memory request address |
| memLen | output | 16 | Clamped request length |
| memDirToMem | output | 1 | Memory request direction |
| dmaEnable | output | 1 | DMA enable toward the core |
| abortPulse | output | 1 | One-cycle request-cancel strobe |

## Verification
Transfers are driven with request lengths below, equal to and above the remaining count. These patterns separate a correct clamp from a pass-through of the raw length, and a count that saturates at zero from one that wraps. Both directions are mixed against both settings of the command direction bit, so a refused request that still moves the counters shows up. Directed runs cover the status bit set by completion, cleared in each of the two clear modes, and overlaid by the core interrupt. A long random run with restarts compares the working count and address against a bench model.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int NUM_REGS = 8;
  localparam int REG_AW = $clog2(NUM_REGS);

  localparam logic [REG_AW-1:0] OFS_CMD       = 3'd0;
  localparam logic [REG_AW-1:0] OFS_START_CNT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_START_ADR = 3'd2;
  localparam logic [REG_AW-1:0] OFS_WORK_CNT  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_WORK_ADR  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_STATUS    = 3'd5;
  localparam logic [REG_AW-1:0] OFS_START_DSC = 3'd6;
  localparam logic [REG_AW-1:0] OFS_WORK_DSC  = 3'd7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dmaOp_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int STAT_W      = 6;
  localparam int STAT_DONE   = 3;
  localparam int STAT_IRQ    = 4;
  localparam logic [STAT_W-1:0] STAT_STICKY = 6'b001110;

  typedef struct packed {
    logic wrCmd;
    logic wrStartCnt;
    logic wrStartAdr;
    logic wrStartDsc;
    logic startLoad;
    logic statusW1c;
    logic statusRdClr;
    logic grant;
    logic complete;
  } dmaStrobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        opField,
  input  logic              statusClrOnRead,
  input  logic              coreCmdDone,
  input  logic              xferReq,
  input  logic              xferDirToMem,
  input  logic              cmdDirToMem,
  output dmaStrobe_t        strobe,
  output logic              dmaEnable,
  output logic              abortPulse
);
  dmaOp_e op;
  assign op = dmaOp_e'(opField);

  always_comb begin
    strobe             = '0;
    strobe.wrCmd       = regWrEn && (regAddr == OFS_CMD);
    strobe.wrStartCnt  = regWrEn && (regAddr == OFS_START_CNT);
    strobe.wrStartAdr  = regWrEn && (regAddr == OFS_START_ADR);
    strobe.wrStartDsc  = regWrEn && (regAddr == OFS_START_DSC);
    strobe.startLoad   = strobe.wrCmd && (op == OP_START);
    strobe.statusW1c   = regWrEn && (regAddr == OFS_STATUS) && !statusClrOnRead;
    strobe.statusRdClr = regRdEn && (regAddr == OFS_STATUS) && statusClrOnRead;
    strobe.grant       = xferReq && (xferDirToMem == cmdDirToMem);
    strobe.complete    = coreCmdDone;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmaEnable  <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      abortPulse <= strobe.wrCmd && (op == OP_ABORT);
      if (strobe.wrCmd) begin
        case (op)
          OP_IDLE:  dmaEnable <= 1'b0;
          OP_START: dmaEnable <= 1'b1;
          default:  dmaEnable <= dmaEnable;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmaStrobe_t        strobe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              coreIrq,
  input  logic [LEN_W-1:0]  xferLen,
  output logic [DATA_W-1:0] regRdData,
  output logic              cmdDirToMem,
  output logic [LEN_W-1:0]  clampLen,
  output logic [DATA_W-1:0] startAdr,
  output logic [DATA_W-1:0] workCnt,
  output logic [DATA_W-1:0] workAdr,
  output logic [STAT_W-1:0] statBits
);
  localparam logic [DATA_W-1:0] WORK_ADR_RST = '1;
  localparam logic [DATA_W-1:0] WORK_DSC_RST = {{(DATA_W-2){1'b1}}, 2'b01};

  logic [DATA_W-1:0] cmdReg, startCnt, startDsc, workDsc;
  logic [DATA_W-1:0] lenWide;
  logic [STAT_W-1:0] statNext;

  assign cmdDirToMem = cmdReg[CMD_DIR_BIT];
  assign lenWide     = DATA_W'(xferLen);
  assign clampLen    = (workCnt < lenWide) ? workCnt[LEN_W-1:0] : xferLen;

  always_comb begin
    statNext = statBits;
    if (strobe.startLoad)   statNext = '0;
    if (strobe.statusW1c)   statNext = statNext & ~(regWrData[STAT_W-1:0] & STAT_STICKY);
    if (strobe.statusRdClr) statNext = statNext & ~STAT_STICKY;
    if (strobe.complete)    statNext[STAT_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdReg   <= '0;
      startCnt <= '0;
      startAdr <= '0;
      startDsc <= '0;
      workCnt  <= '0;
      workAdr  <= WORK_ADR_RST;
      workDsc  <= WORK_DSC_RST;
      statBits <= '0;
    end else begin
      if (strobe.wrCmd)      cmdReg   <= regWrData;
      if (strobe.wrStartCnt) startCnt <= regWrData;
      if (strobe.wrStartAdr) startAdr <= regWrData;
      if (strobe.wrStartDsc) startDsc <= regWrData;
      if (strobe.complete)       workCnt <= '0;
      else if (strobe.startLoad) workCnt <= startCnt;
      else if (strobe.grant)     workCnt <= workCnt - DATA_W'(clampLen);
      if (strobe.startLoad)  workAdr <= startAdr;
      else if (strobe.grant) workAdr <= workAdr + DATA_W'(clampLen);
      if (strobe.startLoad)  workDsc <= startDsc;
      statBits <= statNext;
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CMD:       regRdData = cmdReg;
      OFS_START_CNT: regRdData = startCnt;
      OFS_START_ADR: regRdData = startAdr;
      OFS_WORK_CNT:  regRdData = workCnt;
      OFS_WORK_ADR:  regRdData = workAdr;
      OFS_STATUS: begin
        regRdData = DATA_W'(statBits);
        if (coreIrq) regRdData[STAT_IRQ] = 1'b1;
      end
      OFS_START_DSC: regRdData = startDsc;
      default:       regRdData = workDsc;
    endcase
  end
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              statusClrOnRead,
  input  logic              coreIrq,
  input  logic              coreCmdDone,
  input  logic              xferReq,
  input  logic              xferDirToMem,
  input  logic [LEN_W-1:0]  xferLen,
  output logic              xferGrant,
  output logic              memReqValid,
  output logic [DATA_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  output logic              memDirToMem,
  output logic              dmaEnable,
  output logic              abortPulse
);
  dmaStrobe_t        strobe;
  logic              cmdDirToMem;
  logic [DATA_W-1:0] workCnt, workAdr;
  logic [STAT_W-1:0] statBits;

  bmdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .opField(regWrData[1:0]),
    .statusClrOnRead(statusClrOnRead), .coreCmdDone(coreCmdDone),
    .xferReq(xferReq), .xferDirToMem(xferDirToMem), .cmdDirToMem(cmdDirToMem),
    .strobe(strobe), .dmaEnable(dmaEnable), .abortPulse(abortPulse)
  );

  bmdma_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .coreIrq(coreIrq), .xferLen(xferLen),
    .regRdData(regRdData), .cmdDirToMem(cmdDirToMem), .clampLen(memLen),
    .startAdr(memAddr), .workCnt(workCnt), .workAdr(workAdr),
    .statBits(statBits)
  );

  assign xferGrant   = strobe.grant;
  assign memReqValid = strobe.grant;
  assign memDirToMem = xferDirToMem;
endmodule

// File: rtl/bmdma_checker.sv
module bmdma_checker
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [REG_AW-1:0] regAddr,
  input logic              statusClrOnRead,
  input logic              coreCmdDone,
  input logic              xferReq,
  input logic              xferDirToMem,
  input logic [LEN_W-1:0]  xferLen,
  input logic              xferGrant,
  input logic [LEN_W-1:0]  memLen,
  input logic              abortPulse,
  input logic              cmdDirToMem,
  input logic              startLoad,
  input logic [DATA_W-1:0] workCnt,
  input logic [STAT_W-1:0] statBits
);
  // R9
  grant_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xferGrant |-> (xferReq && xferDirToMem == cmdDirToMem));

  // R7
  clamp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xferGrant |-> (memLen <= xferLen && DATA_W'(memLen) <= workCnt));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xferGrant && !startLoad && !coreCmdDone) |=>
      workCnt == $past(workCnt) - DATA_W'($past(memLen)));

  // R10
  complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreCmdDone |=> (workCnt == '0 && statBits[STAT_DONE]));

  // R6
  abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |-> $past(regWrEn && regAddr == OFS_CMD));

  // R12
  ror_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusClrOnRead && regWrEn && regAddr == OFS_STATUS && !regRdEn && !coreCmdDone)
      |=> $stable(statBits));
endmodule

bind bmdma_channel bmdma_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .statusClrOnRead(statusClrOnRead),
  .coreCmdDone(coreCmdDone), .xferReq(xferReq), .xferDirToMem(xferDirToMem),
  .xferLen(xferLen), .xferGrant(xferGrant), .memLen(memLen),
  .abortPulse(abortPulse), .cmdDirToMem(cmdDirToMem),
  .startLoad(strobe.startLoad), .workCnt(workCnt), .statBits(statBits)
);

// File: tb/test_bmdma_channel.sv
`timescale 1ns/1ps
module test_bmdma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        statusClrOnRead = 1'b0, coreIrq = 1'b0, coreCmdDone = 1'b0;
  logic        xferReq = 1'b0, xferDirToMem = 1'b0;
  logic [15:0] xferLen = '0;
  logic        xferGrant, memReqValid, memDirToMem, dmaEnable, abortPulse;
  logic [31:0] memAddr;
  logic [15:0] memLen;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bmdma_channel i_bmdma_channel (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .statusClrOnRead(statusClrOnRead), .coreIrq(coreIrq),
    .coreCmdDone(coreCmdDone), .xferReq(xferReq), .xferDirToMem(xferDirToMem),
    .xferLen(xferLen), .xferGrant(xferGrant), .memReqValid(memReqValid),
    .memAddr(memAddr), .memLen(memLen), .memDirToMem(memDirToMem),
    .dmaEnable(dmaEnable), .abortPulse(abortPulse)
  );

  // bench model of the channel state
  logic [31:0] mStartCnt, mStartAdr, mWorkCnt, mWorkAdr;
  logic        mDir;

  function automatic logic [31:0] clampOf(logic [31:0] cnt, logic [15:0] len);
    return (cnt < {16'd0, len}) ? cnt : {16'd0, len};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 v = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic startChan(logic [31:0] cnt, logic [31:0] adr, logic dir);
    wrReg(3'd1, cnt);
    wrReg(3'd2, adr);
    wrReg(3'd0, {24'd0, dir, 7'd0} | 32'h3);
    mStartCnt = cnt; mStartAdr = adr; mWorkCnt = cnt; mWorkAdr = adr; mDir = dir;
  endtask

  task automatic xfer(logic dir, logic [15:0] len, string req);
    logic [31:0] g;
    @(negedge clk);
    xferReq = 1'b1; xferDirToMem = dir; xferLen = len;
    #1;
    if (dir == mDir) begin
      g = clampOf(mWorkCnt, len);
      chk({req, " R7 grant"}, {31'd0, xferGrant & memReqValid}, 32'd1);
      chk({req, " R7 len"}, {16'd0, memLen}, g);
      chk({req, " R7 addr"}, memAddr, mStartAdr);
      chk({req, " R7 dir"}, {31'd0, memDirToMem}, {31'd0, dir});
      mWorkCnt = mWorkCnt - g;
      mWorkAdr = mWorkAdr + g;
    end else begin
      chk({req, " R9 refused"}, {30'd0, xferGrant, memReqValid}, 32'd0);
    end
    @(posedge clk); #1;
    xferReq = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    coreCmdDone = 1'b1;
    @(posedge clk); #1;
    coreCmdDone = 1'b0;
    mWorkCnt = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rdReg(3'd0, v); chk("R1 cmd", v, 32'h0);
    rdReg(3'd3, v); chk("R1 workCnt", v, 32'h0);
    rdReg(3'd4, v); chk("R1 workAdr", v, 32'hFFFF_FFFF);
    rdReg(3'd5, v); chk("R1 status", v, 32'h0);
    rdReg(3'd7, v); chk("R1 workDsc", v, 32'hFFFF_FFFD);
    chk("R1 enable/abort", {30'd0, dmaEnable, abortPulse}, 32'd0);

    // R2 start registers
    wrReg(3'd1, 32'h0000_0040); rdReg(3'd1, v); chk("R2 startCnt", v, 32'h40);
    wrReg(3'd2, 32'h1000_2000); rdReg(3'd2, v); chk("R2 startAdr", v, 32'h1000_2000);
    wrReg(3'd6, 32'hCAFE_0010); rdReg(3'd6, v); chk("R2 startDsc", v, 32'hCAFE_0010);

    // R3 working registers ignore writes
    wrReg(3'd3, 32'h1234); rdReg(3'd3, v); chk("R3 workCnt", v, 32'h0);
    wrReg(3'd4, 32'h1234); rdReg(3'd4, v); chk("R3 workAdr", v, 32'hFFFF_FFFF);
    wrReg(3'd7, 32'h1234); rdReg(3'd7, v); chk("R3 workDsc", v, 32'hFFFF_FFFD);

    // R10 completion sets done, then R5 start clears status, R4 copies
    pulseDone();
    rdReg(3'd5, v); chk("R10 done bit", v, 32'h08);
    wrReg(3'd0, 32'h83);
    chk("R4 enable", {31'd0, dmaEnable}, 32'd1);
    rdReg(3'd0, v); chk("R4 cmd stored", v, 32'h83);
    rdReg(3'd3, v); chk("R4 workCnt", v, 32'h40);
    rdReg(3'd4, v); chk("R4 workAdr", v, 32'h1000_2000);
    rdReg(3'd7, v); chk("R4 workDsc", v, 32'hCAFE_0010);
    rdReg(3'd5, v); chk("R5 status cleared", v, 32'h0);
    mStartCnt = 32'h40; mStartAdr = 32'h1000_2000; mWorkCnt = 32'h40;
    mWorkAdr = 32'h1000_2000; mDir = 1'b1;

    // R7/R8/R9 directed: under, refused, over (clamp), at zero
    xfer(1'b1, 16'd16, "short");
    rdReg(3'd3, v); chk("R8 cnt after 16", v, 32'h30);
    rdReg(3'd4, v); chk("R8 adr after 16", v, 32'h1000_2010);
    xfer(1'b0, 16'd8, "wrongdir");
    rdReg(3'd3, v); chk("R9 cnt unchanged", v, 32'h30);
    rdReg(3'd4, v); chk("R9 adr unchanged", v, 32'h1000_2010);
    xfer(1'b1, 16'd100, "clamp");
    rdReg(3'd3, v); chk("R8 cnt at zero", v, 32'h0);
    rdReg(3'd4, v); chk("R8 adr after clamp", v, 32'h1000_2040);
    xfer(1'b1, 16'd5, "empty");
    rdReg(3'd3, v); chk("R8 no wrap", v, 32'h0);

    // R6 abort pulse, burst-flush no-op, idle
    wrReg(3'd0, 32'h82);
    chk("R6 abort high", {31'd0, abortPulse}, 32'd1);
    @(posedge clk); #1;
    chk("R6 abort one cycle", {31'd0, abortPulse}, 32'd0);
    chk("R4 abort keeps enable", {31'd0, dmaEnable}, 32'd1);
    wrReg(3'd0, 32'h81);
    chk("R4 flush keeps enable", {31'd0, dmaEnable}, 32'd1);
    wrReg(3'd0, 32'h80);
    chk("R4 idle disables", {31'd0, dmaEnable}, 32'd0);

    // R11 write-one-to-clear
    pulseDone();
    wrReg(3'd5, 32'h06);
    rdReg(3'd5, v); chk("R11 unselected kept", v, 32'h08);
    wrReg(3'd5, 32'h08);
    rdReg(3'd5, v); chk("R11 done cleared", v, 32'h0);

    // R13 interrupt overlay
    coreIrq = 1'b1;
    rdReg(3'd5, v); chk("R13 irq shown", v, 32'h10);
    coreIrq = 1'b0;
    rdReg(3'd5, v); chk("R13 irq gone", v, 32'h0);

    // R12 clear-on-read
    pulseDone();
    statusClrOnRead = 1'b1;
    wrReg(3'd5, 32'h3F);
    rdReg(3'd5, v); chk("R12 write ignored, read value", v, 32'h08);
    rdReg(3'd5, v); chk("R12 cleared by read", v, 32'h0);
    statusClrOnRead = 1'b0;

    // R10 completion during a run
    startChan(32'd500, 32'h0008_0000, 1'b0);
    xfer(1'b0, 16'd20, "pre-done");
    pulseDone();
    rdReg(3'd3, v); chk("R10 count forced zero", v, 32'h0);
    rdReg(3'd4, v); chk("R10 adr kept", v, 32'h0008_0014);

    // random run against the model
    startChan(32'd300, 32'h4000_0000, 1'b1);
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 16) == 0)
        startChan($urandom % 600, $urandom, 1'($urandom));
      else
        xfer(1'($urandom), 16'($urandom % 80), "rand");
      if ((i % 8) == 7) begin
        rdReg(3'd3, v); chk("R8 rand cnt", v, mWorkCnt);
        rdReg(3'd4, v); chk("R8 rand adr", v, mWorkAdr);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule